// File: doc/BRIEF.md
# Message-Signalled Doorbell Frame Bank

The block turns posted bus writes from peripherals into interrupt edges for a parent interrupt controller. The address space is divided into a number of equally sized doorbell frames laid out back to back from a configurable window base. Each frame owns a group of output lines, eight by default. A peripheral raises an interrupt by writing to the frame's trigger register. The data word of that write names the event, and the block answers with a one-cycle high pulse on the matching line. The parent controller treats each line as a rising-edge input.

The output vector is ordered by frame, then by event, so bit `f*8+e` belongs to event `e` of frame `f`. With per-frame parent bases of 128, 136, 144 and 152, that bit feeds parent input `128 + f*8 + e`, and the four frames therefore cover one contiguous block of 32 lines. A read port is also provided. Any read returns zero one cycle after it is requested and has no other effect.

Top module: `msi_doorbell_bank`

## Requirements
- R1: While `rst` is high, `irq_pulse` and `rd_valid` are zero and writes raise no line. On the first cycle after reset is released, both are still zero.
- R2: A write (`wr_en` high) to byte address `WIN_BASE + f*0x4000 + 0x40` whose data has bits [14:12] = `e` and bits [19:15] = 0 drives `irq_pulse[f*8+e]` high in the cycle after the write is sampled. No other line goes high.
- R3: Each accepted write produces a pulse exactly one cycle long. If the next cycle carries no accepted write, all lines are low again.
- R4: A write that falls inside a frame but at an offset other than 0x40 (bits [13:0] of the address) raises no line.
- R5: A write whose data bits [19:15] are not all zero raises no line. Data bits [11:0] and [31:20] have no effect on the result.
- R6: Accepted writes to different frames in consecutive cycles each produce their own pulse, one cycle apart and in the same order, with none lost.
- R7: A write to an address below `WIN_BASE`, or at or above `WIN_BASE + 4*0x4000`, raises no line.
- R8: A read (`rd_en` high) sets `rd_valid` high in the next cycle with `rd_data` equal to zero.
- R9: A read on its own raises no interrupt line.
- R10: At most one bit of `irq_pulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 32 | Byte address for the write or read |
| wr_data | input | 32 | Write data; carries the event index field |
| rd_en | input | 1 | Read strobe |
| rd_valid | output | 1 | Read response valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read response data, always zero |
| irq_pulse | output | 32 | Edge pulses to the parent, frame-major order |

## Verification
The bench writes every frame/event pair and checks that exactly the one expected bit rises, one cycle late. A wrong frame stride or a wrong field position in the decode would light a neighbouring line or no line at all. It then aims at the filters: offsets one word away from the trigger register, addresses just outside the window at both ends, and event fields with a single bit set above the three-bit index. A design that masks the index instead of rejecting the write would fire a low-numbered line on these. Writes to different frames in back-to-back cycles show whether the pulse registers drop or merge events. A write issued during reset, and reads with and without a write alongside, show whether reset is respected and whether the read path leaks into the interrupt lines.

// File: rtl/msi_db_pkg.sv
package msi_db_pkg;

    // Widest frame or event index the bank supports.
    localparam int SEL_W = 8;

    // Result of the address decode: is it a trigger-register hit, and in which frame.
    typedef struct packed {
        logic             hit;
        logic [SEL_W-1:0] frame;
    } frame_sel_t;

    // Result of the data-field check: is the index in range, and its value.
    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] idx;
    } event_sel_t;

    function automatic int line_of(input int frame, input int evt, input int per_frame);
        return frame * per_frame + evt;
    endfunction

endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode
    import msi_db_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h0030_0000,
    parameter int                FRAME_SHIFT = 14,
    parameter int                NUM_FRAMES  = 4,
    parameter int                TRIG_OFS    = 'h40
) (
    input  logic [ADDR_W-1:0] addr,
    output frame_sel_t        sel
);
    localparam logic [FRAME_SHIFT-1:0] OFS_L = FRAME_SHIFT'(TRIG_OFS);
    localparam logic [ADDR_W-1:0]      NF_L  = ADDR_W'(NUM_FRAMES);

    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] frame_full;
    logic              in_region;
    logic              ofs_ok;

    always_comb begin
        rel        = addr - WIN_BASE;
        frame_full = rel >> FRAME_SHIFT;
        in_region  = (addr >= WIN_BASE) && (frame_full < NF_L);
        ofs_ok     = (rel[FRAME_SHIFT-1:0] == OFS_L);
        sel.hit    = in_region && ofs_ok;
        sel.frame  = frame_full[SEL_W-1:0];
    end
endmodule

// File: rtl/msi_db_event.sv
module msi_db_event
    import msi_db_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int EVT_LSB = 12,
    parameter int FIELD_W = 8,
    parameter int EVENTS  = 8
) (
    input  logic [DATA_W-1:0] data,
    output event_sel_t        sel
);
    localparam int IDX_W = (EVENTS > 1) ? $clog2(EVENTS) : 1;

    logic [FIELD_W-1:0] field;
    logic               unused_bits;

    always_comb begin
        field     = data[EVT_LSB +: FIELD_W];
        sel.valid = ((field >> IDX_W) == '0);
        sel.idx   = SEL_W'(field[IDX_W-1:0]);
    end

    assign unused_bits = ^data;
endmodule

// File: rtl/msi_db_pulse.sv
module msi_db_pulse
    import msi_db_pkg::*;
#(
    parameter int EVENTS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [SEL_W-1:0]  idx,
    output logic [EVENTS-1:0] pulse
);
    for (genvar e = 0; e < EVENTS; e++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) pulse[e] <= 1'b0;
            else     pulse[e] <= fire && (idx == SEL_W'(e));
        end
    end
endmodule

// File: rtl/msi_doorbell_bank.sv
module msi_doorbell_bank
    import msi_db_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                DATA_W      = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h0030_0000,
    parameter int                FRAME_SHIFT = 14,
    parameter int                NUM_FRAMES  = 4,
    parameter int                EVENTS      = 8,
    parameter int                TRIG_OFS    = 'h40,
    parameter int                EVT_LSB     = 12,
    parameter int                FIELD_W     = 8,
    localparam int               LINES       = NUM_FRAMES * EVENTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [LINES-1:0]  irq_pulse
);
    frame_sel_t fsel;
    event_sel_t esel;

    msi_db_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .FRAME_SHIFT(FRAME_SHIFT),
        .NUM_FRAMES(NUM_FRAMES), .TRIG_OFS(TRIG_OFS)
    ) i_decode (
        .addr(bus_addr),
        .sel (fsel)
    );

    msi_db_event #(
        .DATA_W(DATA_W), .EVT_LSB(EVT_LSB), .FIELD_W(FIELD_W), .EVENTS(EVENTS)
    ) i_event (
        .data(wr_data),
        .sel (esel)
    );

    logic accept;
    assign accept = wr_en && fsel.hit && esel.valid;

    for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
        logic fire_f;
        assign fire_f = accept && (fsel.frame == SEL_W'(f));

        msi_db_pulse #(.EVENTS(EVENTS)) i_pulse (
            .clk  (clk),
            .rst  (rst),
            .fire (fire_f),
            .idx  (esel.idx),
            .pulse(irq_pulse[line_of(f, 0, EVENTS) +: EVENTS])
        );
    end

    // Trigger registers are write-only; every read answers with zero.
    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_en;
    end
    assign rd_data = '0;
endmodule

// File: rtl/msi_doorbell_bank_chk.sv
module msi_doorbell_bank_chk #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int FRAME_SHIFT = 14,
    parameter int TRIG_OFS    = 'h40,
    parameter int LINES       = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [LINES-1:0]  irq_pulse
);
    localparam logic [FRAME_SHIFT-1:0] OFS_L = FRAME_SHIFT'(TRIG_OFS);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_pulse == '0 && !rd_valid));

    assert_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse != '0) |-> $past(wr_en));

    assert_bad_offset_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr[FRAME_SHIFT-1:0] != OFS_L) |=> (irq_pulse == '0));

    assert_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rd_valid && rd_data == '0));

    assert_read_no_fire_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> (irq_pulse == '0));

    assert_one_line_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_pulse));
endmodule

bind msi_doorbell_bank msi_doorbell_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_SHIFT(FRAME_SHIFT),
    .TRIG_OFS(TRIG_OFS), .LINES(LINES)
) i_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .bus_addr(bus_addr), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq_pulse(irq_pulse)
);

// File: tb/test_msi_doorbell_bank.sv
module test_msi_doorbell_bank;
    localparam logic [31:0] BASE = 32'h0030_0000;
    localparam int          SPAN = 'h4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] irq_pulse;

    always #10 clk = ~clk;

    msi_doorbell_bank i_msi_doorbell_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .bus_addr(bus_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .irq_pulse(irq_pulse)
    );

    typedef struct {
        logic [31:0] irq;
        logic        rdv;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;

    function automatic logic [31:0] trig(input int f);
        return BASE + 32'(f * SPAN) + 32'h40;
    endfunction

    function automatic logic [31:0] evd(input int e);
        return 32'(e) << 12;
    endfunction

    function automatic logic [31:0] bit_of(input int f, input int e);
        return 32'(1) << (f * 8 + e);
    endfunction

    // Driver: one bus cycle plus the expected outputs one clock later.
    task automatic cyc(input logic we, input logic [31:0] a, input logic [31:0] d,
                       input logic re, input logic [31:0] exp_irq, input string tag);
        exp_t it;
        @(negedge clk);
        wr_en = we; bus_addr = a; wr_data = d; rd_en = re;
        it.irq = exp_irq; it.rdv = re; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input string tag);
        cyc(1'b0, '0, '0, 1'b0, '0, tag);
    endtask

    // Monitor: compare each registered result a quarter period after the edge.
    always begin : mon
        exp_t e;
        @(posedge clk);
        #5;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (irq_pulse !== e.irq || rd_valid !== e.rdv || (e.rdv && rd_data !== '0)) begin
                errors++;
                $display("FAIL %s: irq=%h rdv=%b rdata=%h expected irq=%h rdv=%b rdata=0",
                         e.tag, irq_pulse, rd_valid, rd_data, e.irq, e.rdv);
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R1: writes while in reset must not fire
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            wr_en = 1'b1; bus_addr = trig(i); wr_data = evd(i); rd_en = 1'b1;
            @(posedge clk); #5;
            checks++;
            if (irq_pulse !== '0 || rd_valid !== 1'b0) begin
                errors++;
                $display("FAIL R1: irq=%h rdv=%b expected irq=0 rdv=0", irq_pulse, rd_valid);
            end
        end
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk); #5;
        checks++;
        if (irq_pulse !== '0 || rd_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: irq=%h rdv=%b after release expected 0", irq_pulse, rd_valid);
        end

        // R2: every frame/event pair, separated by idles (R3)
        for (int f = 0; f < 4; f++)
            for (int e = 0; e < 8; e++) begin
                cyc(1'b1, trig(f), evd(e), 1'b0, bit_of(f, e), "R2");
                idle("R3");
            end

        // R4: wrong offsets inside a frame
        cyc(1'b1, BASE + 32'h44, evd(1), 1'b0, '0, "R4");
        cyc(1'b1, BASE + 32'h3C, evd(1), 1'b0, '0, "R4");
        cyc(1'b1, BASE + 32'h4000, evd(2), 1'b0, '0, "R4");
        cyc(1'b1, BASE + 32'h7FC0, evd(2), 1'b0, '0, "R4");

        // R5: upper index bits reject; unrelated bits ignored
        for (int b = 15; b < 20; b++)
            cyc(1'b1, trig(1), evd(3) | (32'(1) << b), 1'b0, '0, "R5");
        cyc(1'b1, trig(2), evd(5) | 32'hFFF0_0FFF, 1'b0, bit_of(2, 5), "R5");
        idle("R5");

        // R7: outside the four windows
        cyc(1'b1, BASE - 32'h4000 + 32'h40, evd(0), 1'b0, '0, "R7");
        cyc(1'b1, trig(4), evd(0), 1'b0, '0, "R7");
        cyc(1'b1, trig(4) + 32'h4000, evd(7), 1'b0, '0, "R7");

        // R6: back-to-back writes to different frames
        cyc(1'b1, trig(0), evd(7), 1'b0, bit_of(0, 7), "R6");
        cyc(1'b1, trig(3), evd(0), 1'b0, bit_of(3, 0), "R6");
        cyc(1'b1, trig(1), evd(4), 1'b0, bit_of(1, 4), "R6");
        cyc(1'b1, trig(2), evd(2), 1'b0, bit_of(2, 2), "R6");
        idle("R3");

        // R8 / R9: reads
        cyc(1'b0, trig(0), evd(1), 1'b1, '0, "R9");
        cyc(1'b0, trig(3), '0, 1'b1, '0, "R8");
        cyc(1'b1, trig(3), evd(6), 1'b1, bit_of(3, 6), "R8");
        idle("R8");

        @(posedge clk);
        #10;
        finish_run();
    end
endmodule